// File: doc/BRIEF.md
# Per-Output Drive and Protection Controller

This block sits between the command registers of a multi-channel low-side switch and its output gate drivers. For every channel it combines the software on/off command with an external PWM pin. It then applies a layered protection policy before it drives the gate enable. The policy has four parts: an over-temperature shutdown that either latches or retries, an optional timed shutdown when the drain voltage stays high while the channel is on, a global overvoltage shutdown with a selectable recovery rule, and an off-state open-load check that is blanked for a while after each command.

Every fault that is detected sets a sticky per-channel flag. An overvoltage trip sets its own sticky flag. Both kinds stay set until a status-read pulse clears them. All timers are parameters counted in system clock cycles. The comparator inputs are treated as already synchronous to the clock. The block has no data stream: all of its pins are plain level or pulse control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `drive_guard`

## Requirements
- R1: When a channel's `pwm_sel` bit is 0, its `gate_en` bit after the next clock edge equals its `out_on` bit.
- R2: When `pwm_sel` is 1, the gate follows `out_on & pwm_pin` if the channel's `pwm_or` bit is 0, and `out_on | pwm_pin` if it is 1.
- R3: A `hot` bit sampled high clears only that channel's gate at the same clock edge and sets that channel's fault flag.
- R4: After `hot` drops, the channel stays off while `hot_retry` is 0 until its `out_on` bit is written 0. With `hot_retry` at 1 it resumes at the first edge with `hot` low.
- R5: A channel with `thermal_only` 0 whose gate is on and whose `vds_high` is sampled high on SHORT_CYC consecutive edges turns off at the last of those edges and sets its fault flag. It stays off until `out_on` is written 0. With `thermal_only` at 1, `vds_high` has no effect.
- R6: `ov_det` sampled high on OV_CYC consecutive edges turns off every gate at the last of those edges and sets `ov_fault`.
- R7: When `ov_det` falls, `ov_restore` at 1 brings back the commanded states at that edge. `ov_restore` at 0 keeps every gate off until the next `cmd_done` pulse.
- R8: An open-load flag is recorded only for a channel whose `out_on` bit is 0 and whose `olp_en` bit is 1.
- R9: A `cmd_done` pulse blanks the open-load check at its own edge and at the BLANK_CYC edges that follow.
- R10: Fault flags and `ov_fault` stay set until `stat_clr` is sampled high. A new fault in the same cycle as the clear wins.
- R11: `any_fault` is 1 whenever any fault flag or `ov_fault` is set.
- R12: While `rst_n` is low, all gates, fault flags, `ov_fault` and `any_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| out_on | input | N_OUT | Per-channel on/off command |
| pwm_sel | input | N_OUT | Per-channel PWM participation |
| pwm_or | input | N_OUT | PWM combine rule: 0 AND, 1 OR |
| thermal_only | input | N_OUT | 1 disables the timed drain-voltage shutdown |
| olp_en | input | N_OUT | Open-load pull-down enabled |
| hot_retry | input | 1 | Thermal recovery: 0 latch, 1 retry |
| ov_restore | input | 1 | Overvoltage recovery: 0 stay off, 1 restore |
| cmd_done | input | 1 | One-cycle pulse when a command is accepted |
| stat_clr | input | 1 | One-cycle pulse when status has been read |
| pwm_pin | input | 1 | External PWM input |
| hot | input | N_OUT | Per-channel over-temperature comparator |
| vds_high | input | N_OUT | Per-channel drain-voltage-high comparator |
| open_det | input | N_OUT | Per-channel off-state open-load comparator |
| ov_det | input | 1 | Supply overvoltage comparator |
| gate_en | output | N_OUT | Registered gate enables |
| fault | output | N_OUT | Sticky per-channel fault flags |
| ov_fault | output | 1 | Sticky overvoltage flag |
| any_fault | output | 1 | OR of all fault flags |

## Verification
The assertions assume that every comparator and configuration input is synchronous to `clk` and changes only between edges. They also assume that `cmd_done` and `stat_clr` are pulses sampled on a single edge, so one pulse counts as one command or one read. The bench meets this by changing every input on the falling clock edge and by raising each pulse for exactly one cycle. This keeps each consecutive-cycle count in the timers exactly as long as the bench intends.

// File: rtl/drvg_pkg.sv
package drvg_pkg;

  typedef enum logic [1:0] {
    OVS_RUN  = 2'd0,
    OVS_SHUT = 2'd1,
    OVS_HOLD = 2'd2
  } ov_state_e;

  function automatic logic mix_drive(input logic on_b, input logic sel_b,
                                     input logic or_b, input logic pin);
    logic r;
    if (!sel_b)    r = on_b;
    else if (or_b) r = on_b | pin;
    else           r = on_b & pin;
    return r;
  endfunction

endpackage

// File: rtl/drvg_mix.sv
module drvg_mix #(
  parameter int N_OUT = 16
) (
  input  logic [N_OUT-1:0] out_on,
  input  logic [N_OUT-1:0] pwm_sel,
  input  logic [N_OUT-1:0] pwm_or,
  input  logic             pwm_pin,
  output logic [N_OUT-1:0] drive
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    assign drive[i] = drvg_pkg::mix_drive(out_on[i], pwm_sel[i], pwm_or[i], pwm_pin);
  end
endmodule

// File: rtl/drvg_blank.sv
module drvg_blank #(
  parameter int BLANK_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic blank
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bcnt <= '0;
    else if (start)      bcnt <= BW'(BLANK_CYC);
    else if (bcnt != '0) bcnt <= bcnt - 1'b1;
  end

  assign blank = start | (bcnt != '0);
endmodule

// File: rtl/drvg_ovmon.sv
module drvg_ovmon
  import drvg_pkg::*;
#(
  parameter int OV_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ov_det,
  input  logic ov_restore,
  input  logic cmd_done,
  output logic block_nxt,
  output logic shut_nxt
);
  localparam int OW = $clog2(OV_CYC + 1);
  localparam logic [OW-1:0] LAST = OW'(OV_CYC - 1);

  ov_state_e     st, st_nxt;
  logic [OW-1:0] ocnt;
  logic          trip;

  assign trip = ov_det & (ocnt == LAST);

  always_comb begin
    st_nxt = st;
    unique case (st)
      OVS_RUN:  if (trip) st_nxt = OVS_SHUT;
      OVS_SHUT: if (!ov_det) st_nxt = ov_restore ? OVS_RUN : OVS_HOLD;
      OVS_HOLD: begin
        if (trip)          st_nxt = OVS_SHUT;
        else if (cmd_done) st_nxt = OVS_RUN;
      end
      default:  st_nxt = OVS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= OVS_RUN;
      ocnt <= '0;
    end else begin
      st <= st_nxt;
      if (!ov_det)          ocnt <= '0;
      else if (ocnt != LAST) ocnt <= ocnt + 1'b1;
    end
  end

  assign block_nxt = (st_nxt != OVS_RUN);
  assign shut_nxt  = (st_nxt == OVS_SHUT);
endmodule

// File: rtl/drvg_lane.sv
module drvg_lane #(
  parameter int SHORT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic on_bit,
  input  logic thermal_only,
  input  logic olp_en,
  input  logic hot_retry,
  input  logic hot,
  input  logic vds_high,
  input  logic open_det,
  input  logic blank,
  input  logic ov_block_nxt,
  input  logic stat_clr,
  output logic gate,
  output logic fault
);
  localparam int SW = $clog2(SHORT_CYC + 1);
  localparam logic [SW-1:0] SLAST = SW'(SHORT_CYC - 1);

  logic          tlatch, slatch;
  logic [SW-1:0] scnt;
  logic          short_cond, trip, tl_nxt, sl_nxt, ol_ev, ev;

  assign short_cond = ~thermal_only & gate & vds_high & ~slatch;
  assign trip       = short_cond & (scnt == SLAST);
  assign tl_nxt     = hot | (tlatch & ~hot_retry & on_bit);
  assign sl_nxt     = trip | (slatch & on_bit);
  assign ol_ev      = open_det & olp_en & ~on_bit & ~blank;
  assign ev         = hot | trip | ol_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlatch <= 1'b0;
      slatch <= 1'b0;
      scnt   <= '0;
      gate   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      tlatch <= tl_nxt;
      slatch <= sl_nxt;
      scnt   <= (short_cond & ~trip) ? scnt + 1'b1 : '0;
      gate   <= drive & ~tl_nxt & ~sl_nxt & ~ov_block_nxt;
      fault  <= ev | (fault & ~stat_clr);
    end
  end
endmodule

// File: rtl/drive_guard.sv
module drive_guard #(
  parameter int N_OUT     = 16,
  parameter int SHORT_CYC = 8,
  parameter int OV_CYC    = 6,
  parameter int BLANK_CYC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] out_on,
  input  logic [N_OUT-1:0] pwm_sel,
  input  logic [N_OUT-1:0] pwm_or,
  input  logic [N_OUT-1:0] thermal_only,
  input  logic [N_OUT-1:0] olp_en,
  input  logic             hot_retry,
  input  logic             ov_restore,
  input  logic             cmd_done,
  input  logic             stat_clr,
  input  logic             pwm_pin,
  input  logic [N_OUT-1:0] hot,
  input  logic [N_OUT-1:0] vds_high,
  input  logic [N_OUT-1:0] open_det,
  input  logic             ov_det,
  output logic [N_OUT-1:0] gate_en,
  output logic [N_OUT-1:0] fault,
  output logic             ov_fault,
  output logic             any_fault
);
  logic [N_OUT-1:0] drive;
  logic             blank, ov_block_nxt, ov_shut_nxt;

  drvg_mix #(.N_OUT(N_OUT)) u_mix (
    .out_on (out_on),
    .pwm_sel(pwm_sel),
    .pwm_or (pwm_or),
    .pwm_pin(pwm_pin),
    .drive  (drive)
  );

  drvg_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cmd_done),
    .blank(blank)
  );

  drvg_ovmon #(.OV_CYC(OV_CYC)) u_ov (
    .clk       (clk),
    .rst_n     (rst_n),
    .ov_det    (ov_det),
    .ov_restore(ov_restore),
    .cmd_done  (cmd_done),
    .block_nxt (ov_block_nxt),
    .shut_nxt  (ov_shut_nxt)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    drvg_lane #(.SHORT_CYC(SHORT_CYC)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .drive       (drive[i]),
      .on_bit      (out_on[i]),
      .thermal_only(thermal_only[i]),
      .olp_en      (olp_en[i]),
      .hot_retry   (hot_retry),
      .hot         (hot[i]),
      .vds_high    (vds_high[i]),
      .open_det    (open_det[i]),
      .blank       (blank),
      .ov_block_nxt(ov_block_nxt),
      .stat_clr    (stat_clr),
      .gate        (gate_en[i]),
      .fault       (fault[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_fault <= 1'b0;
    else        ov_fault <= ov_shut_nxt | (ov_fault & ~stat_clr);
  end

  assign any_fault = (|fault) | ov_fault;
endmodule

// File: rtl/drive_guard_chk.sv
module drive_guard_chk #(
  parameter int N_OUT  = 16,
  parameter int OV_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] out_on,
  input logic             cmd_done,
  input logic             stat_clr,
  input logic [N_OUT-1:0] hot,
  input logic [N_OUT-1:0] vds_high,
  input logic             ov_det,
  input logic [N_OUT-1:0] gate_en,
  input logic [N_OUT-1:0] fault
);
  localparam int RW = $clog2(OV_CYC + 1);

  logic [RW-1:0] ov_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ov_run <= '0;
    else if (!ov_det)             ov_run <= '0;
    else if (ov_run != RW'(OV_CYC)) ov_run <= ov_run + 1'b1;
  end

  // R3
  hot_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot != '0) |=> ((gate_en & $past(hot)) == '0));

  // R6
  ov_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_run == RW'(OV_CYC)) |-> (gate_en == '0));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((fault & $past(fault)) == $past(fault)));

  // R8
  ol_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fault & ~$past(fault) & $past(out_on) & ~$past(hot) & ~$past(vds_high)) == '0));

  // R9
  ol_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> ((fault & ~$past(fault) & ~$past(hot) & ~$past(vds_high)) == '0));
endmodule

bind drive_guard drive_guard_chk #(.N_OUT(N_OUT), .OV_CYC(OV_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .out_on  (out_on),
  .cmd_done(cmd_done),
  .stat_clr(stat_clr),
  .hot     (hot),
  .vds_high(vds_high),
  .ov_det  (ov_det),
  .gate_en (gate_en),
  .fault   (fault)
);

// File: tb/drive_guard_bench.sv
`timescale 1ns/1ps
module drive_guard_bench;
  localparam int N  = 4;
  localparam int SC = 5;
  localparam int OV = 4;
  localparam int BL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] out_on = '0, pwm_sel = '0, pwm_or = '0, thermal_only = '0, olp_en = '0;
  logic hot_retry = 1'b0, ov_restore = 1'b0, cmd_done = 1'b0, stat_clr = 1'b0, pwm_pin = 1'b0;
  logic [N-1:0] hot = '0, vds_high = '0, open_det = '0;
  logic ov_det = 1'b0;
  logic [N-1:0] gate_en, fault;
  logic ov_fault, any_fault;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  drive_guard #(.N_OUT(N), .SHORT_CYC(SC), .OV_CYC(OV), .BLANK_CYC(BL)) u_drive_guard (
    .clk(clk), .rst_n(rst_n), .out_on(out_on), .pwm_sel(pwm_sel), .pwm_or(pwm_or),
    .thermal_only(thermal_only), .olp_en(olp_en), .hot_retry(hot_retry),
    .ov_restore(ov_restore), .cmd_done(cmd_done), .stat_clr(stat_clr), .pwm_pin(pwm_pin),
    .hot(hot), .vds_high(vds_high), .open_det(open_det), .ov_det(ov_det),
    .gate_en(gate_en), .fault(fault), .ov_fault(ov_fault), .any_fault(any_fault)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_gate(input logic [N-1:0] on, input logic [N-1:0] sel,
                                            input logic [N-1:0] orm, input logic p);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++)
      e[i] = sel[i] ? (orm[i] ? (on[i] | p) : (on[i] & p)) : on[i];
    return e;
  endfunction

  task automatic clear_status();
    stat_clr = 1'b1;
    step(1);
    stat_clr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    out_on = '1;
    step(2);
    // R12 reset state
    chk("R12 gate", gate_en, '0);
    chk("R12 fault", fault, '0);
    chk("R12 ov_fault", ov_fault, 0);
    chk("R12 any_fault", any_fault, 0);
    rst_n = 1'b1;
    thermal_only = '1;
    step(1);

    // R1 R2 sweep of every on/sel/or pattern with both pin levels
    for (int v = 0; v < 4096; v++) begin
      for (int p = 0; p < 2; p++) begin
        out_on  = v[3:0];
        pwm_sel = v[7:4];
        pwm_or  = v[11:8];
        pwm_pin = p[0];
        step(1);
        if (v[7:4] == 4'd0) chk("R1 gate follows on", gate_en, exp_gate(v[3:0], v[7:4], v[11:8], p[0]));
        else                chk("R2 pwm combine", gate_en, exp_gate(v[3:0], v[7:4], v[11:8], p[0]));
      end
    end

    out_on = '1; pwm_sel = '0; pwm_or = '0; pwm_pin = 1'b0;
    thermal_only = '0;
    step(1);
    clear_status();
    chk("R11 idle", any_fault, 0);

    // R3 thermal, latch mode
    hot[1] = 1'b1;
    step(1);
    chk("R3 gate", gate_en, 4'b1101);
    chk("R3 fault", fault, 4'b0010);
    chk("R11 any", any_fault, 1);
    hot[1] = 1'b0;
    step(2);
    chk("R4 latched", gate_en, 4'b1101);
    out_on[1] = 1'b0;
    step(1);
    out_on[1] = 1'b1;
    step(1);
    chk("R4 release", gate_en, 4'b1111);
    // R4 retry mode
    hot_retry = 1'b1;
    hot[2] = 1'b1;
    step(1);
    chk("R4 retry off", gate_en, 4'b1011);
    hot[2] = 1'b0;
    step(1);
    chk("R4 retry on", gate_en, 4'b1111);

    // R10 sticky, clear, set beats clear
    chk("R10 sticky", fault, 4'b0110);
    clear_status();
    chk("R10 cleared", fault, 4'b0000);
    chk("R11 cleared", any_fault, 0);
    hot[0] = 1'b1;
    stat_clr = 1'b1;
    step(1);
    stat_clr = 1'b0;
    hot[0] = 1'b0;
    chk("R10 set wins", fault, 4'b0001);
    step(1);
    clear_status();

    // R5 timed short shutdown
    vds_high[3] = 1'b1;
    step(SC - 1);
    chk("R5 before window", gate_en, 4'b1111);
    chk("R5 no fault yet", fault, 4'b0000);
    step(1);
    chk("R5 off", gate_en, 4'b0111);
    chk("R5 fault", fault, 4'b1000);
    vds_high[3] = 1'b0;
    step(2);
    chk("R5 held off", gate_en, 4'b0111);
    out_on[3] = 1'b0;
    step(1);
    out_on[3] = 1'b1;
    step(1);
    chk("R5 release", gate_en, 4'b1111);
    thermal_only[0] = 1'b1;
    vds_high[0] = 1'b1;
    step(3 * SC);
    chk("R5 thermal only ignores vds", gate_en, 4'b1111);
    vds_high[0] = 1'b0;
    clear_status();
    chk("R5 thermal only no fault", fault, 4'b0000);

    // R6 overvoltage trip, R7 restore
    ov_restore = 1'b1;
    ov_det = 1'b1;
    step(OV - 1);
    chk("R6 before window", gate_en, 4'b1111);
    step(1);
    chk("R6 all off", gate_en, 4'b0000);
    chk("R6 ov_fault", ov_fault, 1);
    chk("R11 ov any", any_fault, 1);
    ov_det = 1'b0;
    step(1);
    chk("R7 restore", gate_en, 4'b1111);
    chk("R10 ov sticky", ov_fault, 1);
    clear_status();
    chk("R10 ov cleared", ov_fault, 0);
    // R7 stay-off
    ov_restore = 1'b0;
    ov_det = 1'b1;
    step(OV);
    chk("R6 off again", gate_en, 4'b0000);
    ov_det = 1'b0;
    step(3);
    chk("R7 held off", gate_en, 4'b0000);
    cmd_done = 1'b1;
    step(1);
    cmd_done = 1'b0;
    chk("R7 resume on command", gate_en, 4'b1111);
    step(BL + 2);
    clear_status();

    // R8 open-load qualification
    out_on = 4'b1110;
    olp_en = 4'b0011;
    open_det = 4'b1111;
    step(1);
    chk("R8 only off and enabled", fault, 4'b0001);
    open_det = '0;
    step(1);
    clear_status();

    // R9 blanking after a command
    cmd_done = 1'b1;
    open_det = 4'b0001;
    step(1);
    cmd_done = 1'b0;
    step(BL);
    chk("R9 blanked", fault, 4'b0000);
    step(1);
    chk("R9 after blank", fault, 4'b0001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule